// File: doc/BRIEF.md
# Free-Running 64-bit Cycle Stamp with Pair-Consistency Flag

This block holds a wide free-running cycle counter that software reads through a narrow register port. The port is one half the width of the counter. Software reads the low half first and then the high half. It then reads the control register, whose top bit reports whether the two halves it just fetched belong to the same count value. The block keeps no copy of the count. It only watches for a carry into the upper half between the two half reads, and for any register write in that window. When the flag comes back clear, software repeats the whole three-read sequence.

The counter is zero after reset and stays stopped until software sets the enable bit in the control register. While enabled, it advances by one on every clock and wraps modulo 2^CNT_W. The register addresses, the counter width and the data width are parameters. A second parameter chooses how the counter is built: as two chained half-width slices, or as one full-width adder.

Top module: `stamp_counter64`

## Requirements
- R1: After reset the count is 0 and the enable is 0, and every readable register returns 0.
- R2: A write to the control address (0x103) sets the enable from data bit 0, and control bit 0 reads back the enable. While the enable is 0 the count holds its value.
- R3: While enabled, the count rises by exactly 1 per clock and wraps modulo 2^CNT_W. A read of address 0x104 returns count bits [CNT_W/2-1:0], and a read of 0x105 returns count bits [CNT_W-1:CNT_W/2], both zero-extended to DATA_W.
- R4: Control bit DATA_W-1 (bit 31 by default) reads 1 only when the last pair was a low read followed by a high read with no carry into the upper half. The carries that count are those on the clock edge of the low read and on every edge up to, but not including, the edge of the high read.
- R5: A register write of any kind, to any address, between the low read and the following high read makes that pair report 0.
- R6: A control read clears the flag and discards any pending low read. A high read with no low read since the last control read leaves the flag at 0, and so does a control read between the low and high reads.
- R7: Writes to 0x104 or 0x105 leave the count unchanged. Reads of any address other than 0x103, 0x104 and 0x105 return 0.
- R8: When the flag reads 1, the high value joined above the low value equals the count at the moment of the low read.
- R9: A second low read before the high read restarts the window, so the pair is judged from the most recent low read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register access in this cycle |
| reg_we | input | 1 | 1 = write, 0 = read (when reg_sel is 1) |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the current access (combinational) |

## Verification
The main stimulus is a near-exhaustive sweep on an 8-bit counter with 4-bit halves. The phase of the low read within the low-half period ranges over all 16 values, and the gap before the high read ranges from 0 to 18 idle cycles. This separates pairs that straddle a carry from pairs that do not, including a carry on the low-read edge itself and one on the edge just before the high read. Separate patterns use a stopped counter so that carries cannot occur. On it, the bench interposes writes between the halves, issues high reads with no low read, puts a control read between the halves, and repeats control reads. Each of these isolates one way the flag must drop. A repeated low read across a carry shows that the window restarts.

// File: rtl/stamp_pkg.sv
package stamp_pkg;

   // Decoded single-cycle register access.
   typedef struct packed {
      logic rd_ctrl;
      logic rd_lo;
      logic rd_hi;
      logic wr_ctrl;
      logic wr_any;
   } stamp_acc_t;

   localparam int unsigned STAMP_HALVES = 2;

endpackage

// File: rtl/stamp_decode.sv
module stamp_decode
   import stamp_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned CTRL_ADDR = 32'h103,
   parameter int unsigned LO_ADDR   = 32'h104,
   parameter int unsigned HI_ADDR   = 32'h105
) (
   input  logic              sel,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   output stamp_acc_t        acc
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(LO_ADDR);
   localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(HI_ADDR);

   logic rd;
   logic hit_ctrl;

   assign rd       = sel & ~we;
   assign hit_ctrl = (addr == A_CTRL);

   always_comb begin
      acc         = '0;
      acc.rd_ctrl = rd & hit_ctrl;
      acc.rd_lo   = rd & (addr == A_LO);
      acc.rd_hi   = rd & (addr == A_HI);
      acc.wr_ctrl = sel & we & hit_ctrl;
      acc.wr_any  = sel & we;
   end

endmodule

// File: rtl/stamp_count.sv
module stamp_count #(
   parameter int unsigned CNT_W        = 64,
   parameter bit          SPLIT_HALVES = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   output logic [CNT_W-1:0] cnt_o,
   output logic             carry_o
);

   localparam int unsigned HALF_W = CNT_W / 2;

   // A carry into the upper half happens on this edge.
   assign carry_o = en & (&cnt_o[HALF_W-1:0]);

   generate
      if (SPLIT_HALVES) begin : g_split
         logic [stamp_pkg::STAMP_HALVES-1:0] step;
         assign step[0] = en;
         assign step[1] = carry_o;

         for (genvar k = 0; k < stamp_pkg::STAMP_HALVES; k++) begin : g_slice
            logic [HALF_W-1:0] q;
            always_ff @(posedge clk) begin
               if (!rst_n)
                  q <= '0;
               else if (step[k])
                  q <= q + 1'b1;
            end
            assign cnt_o[k*HALF_W +: HALF_W] = q;
         end
      end else begin : g_wide
         logic [CNT_W-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= '0;
            else if (en)
               q <= q + 1'b1;
         end
         assign cnt_o = q;
      end
   endgenerate

   // R3: one step per enabled clock, wrapping
   a_r3_step : assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (cnt_o == $past(cnt_o) + 1'b1));

   // R2: stopped counter holds
   a_r2_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(cnt_o));

   // R4: upper half moves only after a reported carry
   a_r4_upper_moves_on_carry : assert property (@(posedge clk) disable iff (!rst_n)
      !carry_o |=> $stable(cnt_o[CNT_W-1:HALF_W]));

endmodule

// File: rtl/stamp_track.sv
module stamp_track
   import stamp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  stamp_acc_t acc,
   input  logic       carry,
   output logic       flag_o
);

   logic armed;
   logic spoiled;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         spoiled <= 1'b0;
         flag_o  <= 1'b0;
      end else if (acc.rd_lo) begin
         armed   <= 1'b1;
         spoiled <= carry;
         flag_o  <= 1'b0;
      end else if (acc.rd_hi) begin
         flag_o  <= armed & ~spoiled;
         armed   <= 1'b0;
         spoiled <= 1'b0;
      end else if (acc.rd_ctrl) begin
         flag_o  <= 1'b0;
         armed   <= 1'b0;
         spoiled <= 1'b0;
      end else if (armed & (carry | acc.wr_any)) begin
         spoiled <= 1'b1;
      end
   end

   // R6: orphan high read never reports success
   a_r6_orphan_high : assert property (@(posedge clk) disable iff (!rst_n)
      (acc.rd_hi && !armed) |=> !flag_o);

   // R6: control read consumes the result
   a_r6_ctrl_consumes : assert property (@(posedge clk) disable iff (!rst_n)
      acc.rd_ctrl |=> (!flag_o && !armed));

   // R5: a write inside the window spoils it
   a_r5_write_spoils : assert property (@(posedge clk) disable iff (!rst_n)
      (armed && acc.wr_any) |=> spoiled);

   // R4: a carry inside the window spoils it
   a_r4_carry_spoils : assert property (@(posedge clk) disable iff (!rst_n)
      (armed && carry && !acc.rd_hi && !acc.rd_ctrl) |=> spoiled);

   // R4: success appears only right after a high read
   a_r4_flag_after_high : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o) |-> $past(acc.rd_hi));

endmodule

// File: rtl/stamp_counter64.sv
module stamp_counter64
   import stamp_pkg::*;
#(
   parameter int unsigned CNT_W        = 64,
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned ADDR_W       = 12,
   parameter int unsigned CTRL_ADDR    = 32'h103,
   parameter int unsigned LO_ADDR      = 32'h104,
   parameter int unsigned HI_ADDR      = 32'h105,
   parameter bit          SPLIT_HALVES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata
);

   localparam int unsigned HALF_W   = CNT_W / 2;
   localparam int unsigned FLAG_BIT = DATA_W - 1;

   initial begin
      if (CNT_W % 2 != 0 || CNT_W < 2)
         $error("stamp_counter64: CNT_W must be even and at least 2");
      if (HALF_W > DATA_W)
         $error("stamp_counter64: half of CNT_W must fit in DATA_W");
      if (DATA_W < 2)
         $error("stamp_counter64: DATA_W must be at least 2");
      if (CTRL_ADDR == LO_ADDR || CTRL_ADDR == HI_ADDR || LO_ADDR == HI_ADDR)
         $error("stamp_counter64: register addresses must differ");
      if (ADDR_W < 32 && (CTRL_ADDR >> ADDR_W != 0 || LO_ADDR >> ADDR_W != 0 ||
                          HI_ADDR >> ADDR_W != 0))
         $error("stamp_counter64: address does not fit ADDR_W");
   end

   stamp_acc_t       acc;
   logic             en_q;
   logic [CNT_W-1:0] cnt;
   logic             carry;
   logic             flag;

   stamp_decode #(
      .ADDR_W    (ADDR_W),
      .CTRL_ADDR (CTRL_ADDR),
      .LO_ADDR   (LO_ADDR),
      .HI_ADDR   (HI_ADDR)
   ) u_decode (
      .sel  (reg_sel),
      .we   (reg_we),
      .addr (reg_addr),
      .acc  (acc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         en_q <= 1'b0;
      else if (acc.wr_ctrl)
         en_q <= reg_wdata[0];
   end

   stamp_count #(
      .CNT_W        (CNT_W),
      .SPLIT_HALVES (SPLIT_HALVES)
   ) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en_q),
      .cnt_o   (cnt),
      .carry_o (carry)
   );

   stamp_track u_track (
      .clk    (clk),
      .rst_n  (rst_n),
      .acc    (acc),
      .carry  (carry),
      .flag_o (flag)
   );

   always_comb begin
      reg_rdata = '0;
      if (acc.rd_ctrl) begin
         reg_rdata[FLAG_BIT] = flag;
         reg_rdata[0]        = en_q;
      end else if (acc.rd_lo) begin
         reg_rdata[HALF_W-1:0] = cnt[HALF_W-1:0];
      end else if (acc.rd_hi) begin
         reg_rdata[HALF_W-1:0] = cnt[CNT_W-1:HALF_W];
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^reg_wdata[DATA_W-1:1];

   // R2: enable follows control writes
   a_r2_enable_write : assert property (@(posedge clk) disable iff (!rst_n)
      acc.wr_ctrl |=> (en_q == $past(reg_wdata[0])));

   // R7: count-half writes leave the enable alone
   a_r7_enable_kept : assert property (@(posedge clk) disable iff (!rst_n)
      !acc.wr_ctrl |=> $stable(en_q));

   // R7: no read strobe means zero read data
   a_r7_idle_zero : assert property (@(posedge clk) disable iff (!rst_n)
      !(acc.rd_ctrl || acc.rd_lo || acc.rd_hi) |-> (reg_rdata == '0));

endmodule

// File: tb/stamp_counter64_bench.sv
module stamp_counter64_bench;

   localparam int unsigned CNT_W  = 8;
   localparam int unsigned HALF_W = CNT_W / 2;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned ADDR_W = 12;
   localparam logic [ADDR_W-1:0] A_CTRL = 12'h103;
   localparam logic [ADDR_W-1:0] A_LO   = 12'h104;
   localparam logic [ADDR_W-1:0] A_HI   = 12'h105;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_sel = 1'b0;
   logic              reg_we = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [DATA_W-1:0] reg_rdata;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   stamp_counter64 #(
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_stamp_counter64 (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_sel   (reg_sel),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata)
   );

   // Arithmetic model of the count, from the requirements.
   logic [CNT_W-1:0] m_cnt;
   logic             m_en;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt <= '0;
         m_en  <= 1'b0;
      end else begin
         if (m_en) m_cnt <= m_cnt + 1'b1;
         if (reg_sel && reg_we && reg_addr == A_CTRL) m_en <= reg_wdata[0];
      end
   end

   task automatic check(input bit ok, input string req, input longint got, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d,
                         output logic [CNT_W-1:0] snap);
      @(negedge clk);
      reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
      #5;
      d    = reg_rdata;
      snap = m_cnt;
      @(posedge clk);
      #1 reg_sel = 1'b0;
   endtask

   task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] v);
      @(negedge clk);
      reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = v;
      @(posedge clk);
      #1 begin reg_sel = 1'b0; reg_we = 1'b0; end
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog got %0d expected %0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [DATA_W-1:0] dl, dh, dc, dx;
      logic [CNT_W-1:0]  sl, sh, sc, sx;
      bit                expf;

      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state
      bus_rd(A_CTRL, dc, sc);
      check(dc == 0, "R1 ctrl after reset", dc, 0);
      bus_rd(A_LO, dl, sl);
      check(dl == 0, "R1 low after reset", dl, 0);
      bus_rd(A_HI, dh, sh);
      check(dh == 0, "R1 high after reset", dh, 0);

      // R2: stopped while enable is 0
      idle(5);
      bus_rd(A_LO, dl, sl);
      check(dl == 0, "R2 count held while disabled", dl, 0);

      // R7: unmapped addresses read zero
      bus_rd(12'h106, dx, sx);
      check(dx == 0, "R7 unmapped 0x106", dx, 0);
      bus_rd(12'h100, dx, sx);
      check(dx == 0, "R7 unmapped 0x100", dx, 0);

      // R2: enable and read it back
      bus_wr(A_CTRL, 32'h1);
      bus_rd(A_CTRL, dc, sc);
      check(dc[0] == 1'b1, "R2 enable readback", dc[0], 1);
      check(dc[DATA_W-1] == 1'b0, "R6 flag without pair", dc[DATA_W-1], 0);

      // R3/R4/R8: sweep low-read phase against gap to high read
      for (int ph = 0; ph < 16; ph++) begin
         for (int gap = 0; gap < 19; gap++) begin
            idle(ph);
            bus_rd(A_LO, dl, sl);
            idle(gap);
            bus_rd(A_HI, dh, sh);
            bus_rd(A_CTRL, dc, sc);
            expf = (sh[CNT_W-1:HALF_W] == sl[CNT_W-1:HALF_W]);
            check(dl == DATA_W'(sl[HALF_W-1:0]), "R3 low half", dl, sl[HALF_W-1:0]);
            check(dh == DATA_W'(sh[CNT_W-1:HALF_W]), "R3 high half", dh, sh[CNT_W-1:HALF_W]);
            check(dc[DATA_W-1] == expf, "R4 flag vs carry", dc[DATA_W-1], expf);
            check(dc[0] == 1'b1, "R2 enable stays set", dc[0], 1);
            if (dc[DATA_W-1])
               check({dh[HALF_W-1:0], dl[HALF_W-1:0]} == sl, "R8 joined value",
                     {dh[HALF_W-1:0], dl[HALF_W-1:0]}, sl);
         end
      end

      // R9: repeated low read restarts the window across a carry
      bus_rd(A_LO, dl, sl);
      idle(17);
      for (int k = 0; k < 20; k++) begin
         bus_rd(A_LO, dl, sl);
         if (sl[HALF_W-1:0] < 13) break;
      end
      bus_rd(A_HI, dh, sh);
      bus_rd(A_CTRL, dc, sc);
      expf = (sh[CNT_W-1:HALF_W] == sl[CNT_W-1:HALF_W]);
      check(expf == 1'b1, "R9 setup no carry after second low", expf, 1);
      check(dc[DATA_W-1] == expf, "R9 latest low read rules", dc[DATA_W-1], expf);

      // R2: stop the counter; value must hold
      bus_wr(A_CTRL, 32'h0);
      bus_rd(A_LO, dl, sl);
      bus_rd(A_HI, dh, sh);
      idle(20);
      bus_rd(A_CTRL, dc, sc);
      check(dc[0] == 1'b0, "R2 enable cleared", dc[0], 0);
      bus_rd(A_LO, dx, sx);
      check(dx == dl, "R2 low holds when stopped", dx, dl);
      bus_rd(A_HI, dx, sx);
      check(dx == dh, "R2 high holds when stopped", dx, dh);

      // R4 baseline on a stopped counter
      bus_rd(A_LO, dl, sl);
      bus_rd(A_HI, dh, sh);
      bus_rd(A_CTRL, dc, sc);
      check(dc[DATA_W-1] == 1'b1, "R4 clean pair", dc[DATA_W-1], 1);

      // R6: control read consumes the flag
      bus_rd(A_CTRL, dc, sc);
      check(dc[DATA_W-1] == 1'b0, "R6 second ctrl read", dc[DATA_W-1], 0);

      // R5 + R7: write to low address inside window
      bus_rd(A_LO, dl, sl);
      bus_wr(A_LO, 32'hFFFF_FFFF);
      bus_rd(A_HI, dh, sh);
      bus_rd(A_CTRL, dc, sc);
      check(dc[DATA_W-1] == 1'b0, "R5 write to low spoils", dc[DATA_W-1], 1'b0);
      bus_rd(A_LO, dx, sx);
      check(dx == dl, "R7 low unchanged by write", dx, dl);

      // R5 + R7: write to high address inside window
      bus_rd(A_LO, dl, sl);
      bus_wr(A_HI, 32'hFFFF_FFFF);
      bus_rd(A_HI, dh, sh);
      bus_rd(A_CTRL, dc, sc);
      check(dc[DATA_W-1] == 1'b0, "R5 write to high spoils", dc[DATA_W-1], 0);
      check(dh == DATA_W'(sl[CNT_W-1:HALF_W]), "R7 high unchanged by write", dh,
            sl[CNT_W-1:HALF_W]);

      // R5: write to an unmapped address inside window
      bus_rd(A_LO, dl, sl);
      bus_wr(12'h0, 32'h0);
      bus_rd(A_HI, dh, sh);
      bus_rd(A_CTRL, dc, sc);
      check(dc[DATA_W-1] == 1'b0, "R5 unmapped write spoils", dc[DATA_W-1], 0);

      // R6: high read with no low read
      bus_rd(A_HI, dh, sh);
      bus_rd(A_CTRL, dc, sc);
      check(dc[DATA_W-1] == 1'b0, "R6 orphan high read", dc[DATA_W-1], 0);

      // R6: control read between halves
      bus_rd(A_LO, dl, sl);
      bus_rd(A_CTRL, dc, sc);
      bus_rd(A_HI, dh, sh);
      bus_rd(A_CTRL, dc, sc);
      check(dc[DATA_W-1] == 1'b0, "R6 ctrl between halves", dc[DATA_W-1], 0);

      // R4 again after all the spoiled cases
      bus_rd(A_LO, dl, sl);
      bus_rd(A_HI, dh, sh);
      bus_rd(A_CTRL, dc, sc);
      check(dc[DATA_W-1] == 1'b1, "R4 recovery pair", dc[DATA_W-1], 1);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule